// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front-End

This block is the digital control logic in front of a 16-bit voltage-output converter core. A host drives it over a 3-wire slave serial port: an active-low chip select, a serial clock and a data line. Bits are sampled on rising serial clock edges, MSB first, into a shift register. When chip select returns high, the shift register is copied into a staging register. A separate active-low load strobe then moves the staging register into the converter latch, and that latch's value is the code the converter core receives.

The design runs entirely in one fast system clock domain. All four host pins pass through two-flop synchronisers, and edges are detected after synchronisation. The system clock must run at least four times faster than the serial clock. Both holding registers reset to mid-scale. The shift register has no reset, so the first frame after power-up should carry at least 16 bits. A frame longer than 16 clocks leaves the most recent 16 bits. A shorter frame pushes its bits in at the bottom and leaves older bits in the upper positions.

A strobe that is tied low makes the latch follow every new staged word. A strobe that goes low while a frame is in progress is a protocol violation: the block raises a one-cycle error pulse and stops the latch from updating until the strobe has gone high and then low again with chip select high.

Top module: `dacfe_top`

## Requirements
- R1: After reset, `staged_o` and `dac_code_o` both equal 16'h8000, `frame_bits_o` is 0, and `short_frame_o` and `strobe_err_o` are 0.
- R2: While chip select is low, each rising serial clock edge shifts the `sdi_i` level into bit 0 of the shift register and moves the older bits up one place, so the first bit sent ends up in the MSB. A rising chip select copies the shift register into `staged_o`.
- R3: While chip select is high, activity on the serial clock and data pins leaves the shift register unchanged. A following frame with zero clocks therefore stages the previous word unchanged.
- R4: A frame with more than 16 clocks stages only the last 16 bits received.
- R5: A frame with n < 16 clocks stages the old shift contents shifted up by n places, with the n new bits in bits n-1..0.
- R6: While the load strobe is high, `dac_code_o` holds its value. While the strobe is low and chip select is high, `dac_code_o` takes the value of `staged_o`.
- R7: With the strobe held low throughout, `dac_code_o` equals the newly staged word one system clock after `staged_o` updates.
- R8: A falling strobe edge while chip select is low gives exactly one cycle of `strobe_err_o` high. After that, `dac_code_o` does not change until the strobe has been seen high and then low again while chip select is high.
- R9: `frame_bits_o` clears on a falling chip select, counts rising serial clock edges in the frame, stops at 16, and holds its value after the frame ends.
- R10: On a rising chip select, `short_frame_o` becomes 1 if the frame had fewer than 16 clocks and 0 otherwise. It holds that value until the next frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low chip select from host |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| ldac_n_i | input | 1 | Active-low latch load strobe |
| dac_code_o | output | 16 | Latched code to converter core |
| staged_o | output | 16 | Staging register contents |
| frame_bits_o | output | 5 | Serial clocks counted in current/last frame, saturating at 16 |
| short_frame_o | output | 1 | Last completed frame had fewer than 16 clocks |
| strobe_err_o | output | 1 | One-cycle pulse on strobe-during-frame violation |

## Verification
A pin change reaches the synchronised domain after two system clocks. A rising chip select updates `staged_o` and `short_frame_o` three clocks after the pin changes. With the strobe low, `dac_code_o` follows one clock after that. A falling strobe updates the latch three clocks after the pin changes. The bench therefore waits eight system clocks after each frame or strobe change before it samples outputs on the falling clock edge, which leaves margin past every one of these latencies. The error pulse is counted on every falling clock edge across the whole violation window, so a missing pulse or a pulse that lasts more than one cycle are both detected.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int WORD_W = 16;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Host-side pins, carried together through the synchronisers
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdi;
        logic ldac_n;
    } pins_t;

    localparam pins_t IDLE_PINS = '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0, ldac_n: 1'b1};

    function automatic word_t mid_scale();
        word_t w;
        w = '0;
        w[WORD_W-1] = 1'b1;
        return w;
    endfunction

    function automatic cnt_t full_count();
        return cnt_t'(WORD_W);
    endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync
    import dacfe_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins_in,
    output pins_t pins_out
);

    pins_t chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= IDLE_PINS;
        else     chain[0] <= pins_in;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= IDLE_PINS;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign pins_out = chain[STAGES-1];

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
    import dacfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins,
    output word_t shreg,
    output logic  cs_rise,
    output cnt_t  bit_cnt
);

    logic cs_d;
    logic sclk_d;
    logic cs_fall;
    logic shift_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= pins.cs_n;
            sclk_d <= pins.sclk;
        end
    end

    assign cs_rise  = pins.cs_n & ~cs_d;
    assign cs_fall  = ~pins.cs_n & cs_d;
    assign shift_en = ~pins.cs_n & pins.sclk & ~sclk_d;

    // Shift register deliberately carries no reset
    always_ff @(posedge clk) begin
        if (shift_en) shreg <= {shreg[WORD_W-2:0], pins.sdi};
    end

    always_ff @(posedge clk) begin
        if (rst)                                   bit_cnt <= '0;
        else if (cs_fall)                          bit_cnt <= '0;
        else if (shift_en && bit_cnt != full_count()) bit_cnt <= bit_cnt + cnt_t'(1);
    end

endmodule

// File: rtl/dacfe_latch.sv
module dacfe_latch
    import dacfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n_s,
    input  logic  ldac_n_s,
    input  logic  cs_rise,
    input  word_t shreg,
    input  cnt_t  bit_cnt,
    output word_t staged,
    output word_t dac_code,
    output logic  short_flag,
    output logic  err_pulse,
    output logic  blocked
);

    logic ldac_d;
    logic ldac_fall;
    logic violation;
    logic load_en;

    always_ff @(posedge clk) begin
        if (rst) ldac_d <= 1'b1;
        else     ldac_d <= ldac_n_s;
    end

    assign ldac_fall = ~ldac_n_s & ldac_d;
    assign violation = ldac_fall & ~cs_n_s;
    assign load_en   = ~ldac_n_s & cs_n_s & ~blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged     <= mid_scale();
            short_flag <= 1'b0;
        end else if (cs_rise) begin
            staged     <= shreg;
            short_flag <= (bit_cnt < full_count());
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          dac_code <= mid_scale();
        else if (load_en) dac_code <= staged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blocked   <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= violation;
            if (violation)                  blocked <= 1'b1;
            else if (cs_n_s && ldac_n_s)    blocked <= 1'b0;
        end
    end

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
    import dacfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              ldac_n_i,
    output logic [WORD_W-1:0] dac_code_o,
    output logic [WORD_W-1:0] staged_o,
    output logic [CNT_W-1:0]  frame_bits_o,
    output logic              short_frame_o,
    output logic              strobe_err_o
);

    pins_t pins_raw;
    pins_t pins_s;
    word_t shreg;
    logic  cs_rise;
    cnt_t  bit_cnt;
    word_t staged;
    word_t dac_code;
    logic  blocked;

    assign pins_raw = '{cs_n: cs_n_i, sclk: sclk_i, sdi: sdi_i, ldac_n: ldac_n_i};

    dacfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pins_in  (pins_raw),
        .pins_out (pins_s)
    );

    dacfe_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .pins    (pins_s),
        .shreg   (shreg),
        .cs_rise (cs_rise),
        .bit_cnt (bit_cnt)
    );

    dacfe_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .cs_n_s     (pins_s.cs_n),
        .ldac_n_s   (pins_s.ldac_n),
        .cs_rise    (cs_rise),
        .shreg      (shreg),
        .bit_cnt    (bit_cnt),
        .staged     (staged),
        .dac_code   (dac_code),
        .short_flag (short_frame_o),
        .err_pulse  (strobe_err_o),
        .blocked    (blocked)
    );

    assign dac_code_o   = dac_code;
    assign staged_o     = staged;
    assign frame_bits_o = bit_cnt;

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
    import dacfe_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input word_t dac_code_o,
    input word_t staged_o,
    input cnt_t  frame_bits_o,
    input logic  strobe_err_o,
    input pins_t pins_s,
    input logic  cs_rise,
    input word_t shreg,
    input logic  blocked
);

    // R6
    latch_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_code_o) |-> $past(!pins_s.ldac_n && pins_s.cs_n && !blocked));

    // R2
    staged_on_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(staged_o) |-> $past(cs_rise));

    // R3
    idle_shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pins_s.cs_n) |-> $stable(shreg));

    // R8
    err_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_err_o |=> !strobe_err_o);

    // R9
    count_sat_chk: assert property (@(posedge clk) disable iff (rst)
        frame_bits_o <= full_count());

endmodule

bind dacfe_top dacfe_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .dac_code_o   (dac_code_o),
    .staged_o     (staged_o),
    .frame_bits_o (frame_bits_o),
    .strobe_err_o (strobe_err_o),
    .pins_s       (pins_s),
    .cs_rise      (cs_rise),
    .shreg        (shreg),
    .blocked      (blocked)
);

// File: tb/tb_dacfe_top.sv
module tb_dacfe_top;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        ldac_n = 1'b1;
    logic [15:0] dac_code;
    logic [15:0] staged;
    logic [4:0]  frame_bits;
    logic        short_frame;
    logic        strobe_err;

    int          n_checks = 0;
    int          n_fail = 0;
    int          err_seen = 0;
    logic [15:0] model = 16'h0;
    logic [15:0] latched_exp;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacfe_top dut (
        .clk           (clk),
        .rst           (rst),
        .cs_n_i        (cs_n),
        .sclk_i        (sclk),
        .sdi_i         (sdi),
        .ldac_n_i      (ldac_n),
        .dac_code_o    (dac_code),
        .staged_o      (staged),
        .frame_bits_o  (frame_bits),
        .short_frame_o (short_frame),
        .strobe_err_o  (strobe_err)
    );

    always @(negedge clk) if (strobe_err) err_seen++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends n bits of pat, MSB of the n-bit value first; updates the bench model
    task automatic send_frame(input int n, input logic [31:0] pat);
        @(negedge clk) cs_n = 1'b0;
        wait_clk(3);
        for (int i = 0; i < n; i++) begin
            sdi = pat[n-1-i];
            wait_clk(2);
            sclk = 1'b1;
            model = {model[14:0], pat[n-1-i]};
            wait_clk(2);
            sclk = 1'b0;
        end
        wait_clk(3);
        cs_n = 1'b1;
        wait_clk(SETTLE);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);

        // R1 reset state
        check("R1 dac", dac_code, 16'h8000);
        check("R1 staged", staged, 16'h8000);
        check("R1 count", frame_bits, 0);
        check("R1 short", short_frame, 0);
        check("R1 err", strobe_err, 0);

        // R2/R6: full frame with strobe high, latch holds
        send_frame(16, 32'hA5C3);
        check("R2 staged", staged, model);
        check("R6 hold", dac_code, 16'h8000);
        check("R9 count16", frame_bits, 16);
        check("R10 full", short_frame, 0);
        ldac_n = 1'b0;
        wait_clk(SETTLE);
        check("R6 load", dac_code, 16'hA5C3);
        ldac_n = 1'b1;
        wait_clk(SETTLE);

        // R3: serial activity while chip select high is ignored
        for (int i = 0; i < 10; i++) begin
            sdi = i[0];
            wait_clk(2);
            sclk = 1'b1;
            wait_clk(2);
            sclk = 1'b0;
        end
        send_frame(0, 32'h0);
        check("R3 staged", staged, 16'hA5C3);
        check("R9 count0", frame_bits, 0);
        check("R10 short0", short_frame, 1);

        // R4/R5/R7/R9/R10: length sweep with strobe tied low
        ldac_n = 1'b0;
        wait_clk(SETTLE);
        for (int n = 1; n <= 20; n++) begin
            logic [31:0] pat;
            pat = 32'h9E3779B9 * n;
            send_frame(n, pat);
            if (n > 16) check("R4 staged", staged, pat[15:0]);
            else        check("R5 staged", staged, model);
            check("R7 dac", dac_code, model);
            check("R9 count", frame_bits, (n > 16) ? 16 : n);
            check("R10 short", short_frame, (n < 16) ? 1 : 0);
        end
        ldac_n = 1'b1;
        wait_clk(SETTLE);

        // R8: strobe pulled low in the middle of a frame
        latched_exp = dac_code;
        err_seen = 0;
        @(negedge clk) cs_n = 1'b0;
        wait_clk(3);
        for (int i = 0; i < 16; i++) begin
            if (i == 4) begin
                ldac_n = 1'b0;
                wait_clk(2);
            end
            sdi = i[1] ^ i[0];
            wait_clk(2);
            sclk = 1'b1;
            model = {model[14:0], i[1] ^ i[0]};
            wait_clk(2);
            sclk = 1'b0;
        end
        wait_clk(3);
        cs_n = 1'b1;
        wait_clk(SETTLE);
        check("R8 pulses", err_seen, 1);
        check("R8 staged", staged, model);
        check("R8 blocked", dac_code, latched_exp);
        ldac_n = 1'b1;
        wait_clk(SETTLE);
        check("R8 still", dac_code, latched_exp);
        ldac_n = 1'b0;
        wait_clk(SETTLE);
        check("R8 release", dac_code, model);
        ldac_n = 1'b1;
        wait_clk(SETTLE);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule